// File: doc/BRIEF.md
# JTAG Debug Command Decoder

This block holds the debug command word of a test access port and turns it into resource selects and action strobes. While the TAP controller sits in Shift-IR, a 10-bit command shifts in serially from `tdi`. The word becomes active only when the controller passes Update-IR. The command carries a read/write flag, a single-step/resume flag (go), an exit-debug flag and a 7-bit resource selector. The selector decides which data path lies between `tdi` and `tdo` during the following DR scan. That path is one of three: an internal 1-bit bypass stage, an internal read-only identification register, or one of nine external debug registers.

Nothing in the command acts when it is loaded. Every read capture, write strobe, go pulse and exit pulse waits until the controller passes Update-DR. This holds even for commands whose selected resource carries no data. The TAP state machine stays outside the block and supplies one-cycle state indications. The external registers receive only their one-hot select and the strobes, and they return their serial output on `ext_tdo`.

Top module: `dbg_cmd_decoder`

## Requirements
- R1: After a synchronous reset, both the command shift stage and the active command hold 10'b1101100000 (bit 9 down to bit 0), so shifting out from bit 0 yields 0,0,0,0,0,1,1,0,1,1. `res_sel` is zero and every pulse output is low.
- R2: On each clock where `shift_ir` is high, `tdi` enters bit 9 of the shift stage and the other bits move one place toward bit 0. While `shift_ir` is high, `tdo` shows bit 0 of the shift stage.
- R3: A shifted command takes effect only through `update_ir`. Shifting alone leaves the active selection unchanged. `res_sel` reflects a new command two clocks after `update_ir` is sampled high.
- R4: Command bit 0 is read/write (1 = read, 0 = write), bit 1 is go and bit 2 is exit. Bits 3..9 are the select code, with bit 3 as its MSB. `res_sel` is one-hot at most, with this mapping: index 0 = 0010000 (CPU scan), 1 = 0010010 (debug control), 2..5 = 0100000..0100011 (instruction address compare 1..4), 6..7 = 0100100..0100101 (data address compare 1..2), 8 = 0100110 (data value compare 1).
- R5: `dr_write` or `dr_read` pulses for exactly one clock, in the cycle after `update_dr` is sampled high. It fires only when a `res_sel` bit is set, and the read/write bit picks which one.
- R6: `go_pulse` and `exit_pulse` follow their command bits as one-clock pulses in the cycle after `update_dr` is sampled high, whatever the select code. Passing `update_ir` alone produces no pulse of any kind.
- R7: Select code 0010001 and every code not listed in R4 or R8 give a 1-bit bypass path. It captures 0 at `capture_dr`, so `tdo` in a DR shift shows the `tdi` bit of the previous shift. No read or write strobe fires for these codes.
- R8: Select code 0000010 makes `capture_dr` load the parameter `ID_CODE`, which shifts out bit 0 first. Neither a read nor a write strobe fires for it, and data shifted in does not alter the value captured at the next scan.
- R9: While a `res_sel` bit is set and `shift_ir` is low, `tdo` follows `ext_tdo`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tdi | input | 1 | Serial test data in |
| shift_ir | input | 1 | TAP is in Shift-IR |
| update_ir | input | 1 | TAP is in Update-IR |
| capture_dr | input | 1 | TAP is in Capture-DR |
| shift_dr | input | 1 | TAP is in Shift-DR |
| update_dr | input | 1 | TAP is in Update-DR |
| ext_tdo | input | 1 | Serial output of the selected external debug register |
| tdo | output | 1 | Serial test data out |
| res_sel | output | 9 | One-hot select of the external debug registers |
| dr_write | output | 1 | Write strobe for the selected register |
| dr_read | output | 1 | Read capture strobe for the selected register |
| go_pulse | output | 1 | Single-step/resume request |
| exit_pulse | output | 1 | Exit-debug request |

## Verification
The bench shifts in a fresh command without `update_ir` and then runs a DR scan. A decoder that acted on the shift stage would leave bypass at that point. The bench then loads commands with go or exit set and passes only Update-IR, so a design that fired actions at command load would produce a pulse where none belongs. Write commands aimed at the identification register follow, and an implementation that strobed external logic or kept the shifted-in data would show a spurious `dr_write` or a corrupted ID on the next scan. Reserved codes at both ends of the code space, and the bypass code with go and exit set, expose any decoder that strobes a non-existent resource or that ties go and exit to a data access.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;

  localparam int CMD_W   = 10;
  localparam int RS_W    = 7;
  localparam int NUM_RES = 9;

  localparam int BIT_RW  = 0;
  localparam int BIT_GO  = 1;
  localparam int BIT_EX  = 2;
  localparam int RS_LSB  = 3;

  localparam logic [CMD_W-1:0] CMD_RST = 10'b11_0110_0000;
  localparam logic [RS_W-1:0]  RS_IDREG = 7'h02;
  localparam logic [RS_W-1:0]  RS_BYP   = 7'h11;

  typedef struct packed {
    logic go;
    logic ex;
    logic wr;
    logic rd;
  } act_t;

  // Select code of external resource index idx (index 0 = CPU scan)
  function automatic logic [RS_W-1:0] res_code(input int idx);
    if (idx == 0)      return 7'h10;
    else if (idx == 1) return 7'h12;
    else               return 7'h20 + RS_W'(idx - 2);
  endfunction

  // Command bit RS_LSB carries the MSB of the select code
  function automatic logic [RS_W-1:0] rs_of(input logic [CMD_W-1:0] c);
    logic [RS_W-1:0] r;
    for (int j = 0; j < RS_W; j++) r[RS_W-1-j] = c[RS_LSB+j];
    return r;
  endfunction

endpackage

// File: rtl/dbg_cmd_ir.sv
module dbg_cmd_ir
  import dbg_cmd_pkg::*;
#(
  parameter int W = CMD_W,
  parameter logic [W-1:0] RST_VAL = CMD_RST
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tdi,
  input  logic         shift_ir,
  input  logic         update_ir,
  output logic         ir_tdo,
  output logic [W-1:0] cmd_q
);

  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= RST_VAL;
      cmd_q <= RST_VAL;
    end else begin
      if (shift_ir)  sr_q  <= {tdi, sr_q[W-1:1]};
      if (update_ir) cmd_q <= sr_q;
    end
  end

  assign ir_tdo = sr_q[0];

  // R3: the active command only changes through update_ir
  assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(update_ir) |-> $stable(cmd_q));

endmodule

// File: rtl/dbg_sel_decode.sv
module dbg_sel_decode
  import dbg_cmd_pkg::*;
#(
  parameter int W  = CMD_W,
  parameter int NR = NUM_RES
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  cmd,
  output logic [NR-1:0] res_sel_q,
  output logic          id_sel_q
);

  logic [RS_W-1:0] rs;
  logic [NR-1:0]   hit;

  assign rs = rs_of(cmd);

  for (genvar i = 0; i < NR; i++) begin : g_hit
    assign hit[i] = (rs == res_code(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_sel_q <= '0;
      id_sel_q  <= 1'b0;
    end else begin
      res_sel_q <= hit;
      id_sel_q  <= (rs == RS_IDREG);
    end
  end

  // R4: at most one path is chosen at a time
  assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({res_sel_q, id_sel_q}));

endmodule

// File: rtl/dbg_dr_path.sv
module dbg_dr_path #(
  parameter int ID_W = 32,
  parameter logic [ID_W-1:0] ID_CODE = 32'h2C5A_3F1D
) (
  input  logic clk,
  input  logic rst,
  input  logic tdi,
  input  logic capture_dr,
  input  logic shift_dr,
  input  logic shift_ir,
  input  logic ir_tdo,
  input  logic id_sel,
  input  logic data_sel,
  input  logic ext_tdo,
  output logic tdo
);

  logic [ID_W-1:0] id_sr_q;
  logic            byp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      id_sr_q <= ID_CODE;
      byp_q   <= 1'b0;
    end else if (capture_dr) begin
      id_sr_q <= ID_CODE;
      byp_q   <= 1'b0;
    end else if (shift_dr) begin
      if (id_sel) id_sr_q <= {tdi, id_sr_q[ID_W-1:1]};
      byp_q <= tdi;
    end
  end

  always_comb begin
    if (shift_ir)      tdo = ir_tdo;
    else if (id_sel)   tdo = id_sr_q[0];
    else if (data_sel) tdo = ext_tdo;
    else               tdo = byp_q;
  end

  // R8: a capture always presents the first identification bit
  assert_id_capture_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(capture_dr) && !shift_ir && id_sel) |-> (tdo == ID_CODE[0]));

  // R7: bypass captures zero
  assert_byp_capture_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(capture_dr) && !shift_ir && !id_sel && !data_sel) |-> (tdo == 1'b0));

endmodule

// File: rtl/dbg_action_gen.sv
module dbg_action_gen
  import dbg_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic update_dr,
  input  logic cmd_rw,
  input  logic cmd_go,
  input  logic cmd_ex,
  input  logic data_sel,
  output act_t act_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= '0;
    end else if (update_dr) begin
      act_q.go <= cmd_go;
      act_q.ex <= cmd_ex;
      act_q.wr <= data_sel & ~cmd_rw;
      act_q.rd <= data_sel & cmd_rw;
    end else begin
      act_q <= '0;
    end
  end

  // R6: go and exit only follow an Update-DR
  assert_go_upd_R6: assert property (@(posedge clk) disable iff (rst)
    (act_q.go || act_q.ex) |-> $past(update_dr));

  // R6: go lasts a single clock
  assert_go_single_R6: assert property (@(posedge clk) disable iff (rst)
    act_q.go |=> !act_q.go);

  // R5: data strobes require a selected external resource
  assert_strobe_sel_R5: assert property (@(posedge clk) disable iff (rst)
    (act_q.wr || act_q.rd) |-> ($past(data_sel) && $past(update_dr)));

endmodule

// File: rtl/dbg_cmd_decoder.sv
module dbg_cmd_decoder
  import dbg_cmd_pkg::*;
#(
  parameter int ID_W = 32,
  parameter logic [ID_W-1:0] ID_CODE = 32'h2C5A_3F1D
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tdi,
  input  logic               shift_ir,
  input  logic               update_ir,
  input  logic               capture_dr,
  input  logic               shift_dr,
  input  logic               update_dr,
  input  logic               ext_tdo,
  output logic               tdo,
  output logic [NUM_RES-1:0] res_sel,
  output logic               dr_write,
  output logic               dr_read,
  output logic               go_pulse,
  output logic               exit_pulse
);

  logic [CMD_W-1:0] cmd_q;
  logic             ir_tdo;
  logic             id_sel;
  logic             data_sel;
  act_t             act;

  dbg_cmd_ir #(.W(CMD_W), .RST_VAL(CMD_RST)) u_ir (
    .clk       (clk),
    .rst       (rst),
    .tdi       (tdi),
    .shift_ir  (shift_ir),
    .update_ir (update_ir),
    .ir_tdo    (ir_tdo),
    .cmd_q     (cmd_q)
  );

  dbg_sel_decode #(.W(CMD_W), .NR(NUM_RES)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd_q),
    .res_sel_q (res_sel),
    .id_sel_q  (id_sel)
  );

  assign data_sel = |res_sel;

  dbg_dr_path #(.ID_W(ID_W), .ID_CODE(ID_CODE)) u_path (
    .clk        (clk),
    .rst        (rst),
    .tdi        (tdi),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .shift_ir   (shift_ir),
    .ir_tdo     (ir_tdo),
    .id_sel     (id_sel),
    .data_sel   (data_sel),
    .ext_tdo    (ext_tdo),
    .tdo        (tdo)
  );

  dbg_action_gen u_act (
    .clk       (clk),
    .rst       (rst),
    .update_dr (update_dr),
    .cmd_rw    (cmd_q[BIT_RW]),
    .cmd_go    (cmd_q[BIT_GO]),
    .cmd_ex    (cmd_q[BIT_EX]),
    .data_sel  (data_sel),
    .act_q     (act)
  );

  assign go_pulse   = act.go;
  assign exit_pulse = act.ex;
  assign dr_write   = act.wr;
  assign dr_read    = act.rd;

endmodule

// File: tb/dbg_cmd_decoder_bench.sv
module dbg_cmd_decoder_bench;

  localparam int NR = 9;
  localparam logic [31:0] IDC = 32'h2C5A_3F1D;
  localparam logic [9:0]  RST_WORD = 10'b11_0110_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tdi = 1'b0, shift_ir = 1'b0, update_ir = 1'b0;
  logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, ext_tdo = 1'b0;
  wire          tdo, dr_write, dr_read, go_pulse, exit_pulse;
  wire [NR-1:0] res_sel;

  always #4 clk = ~clk;

  dbg_cmd_decoder #(.ID_W(32), .ID_CODE(IDC)) u_dbg_cmd_decoder (
    .clk(clk), .rst(rst), .tdi(tdi), .shift_ir(shift_ir), .update_ir(update_ir),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .ext_tdo(ext_tdo), .tdo(tdo), .res_sel(res_sel), .dr_write(dr_write),
    .dr_read(dr_read), .go_pulse(go_pulse), .exit_pulse(exit_pulse)
  );

  typedef enum int {K_TDO, K_ACT, K_SEL} kind_t;
  typedef enum int {M_NONE, M_ID, M_BYP, M_EXT} mode_t;
  typedef struct {
    int          cyc;
    kind_t       kind;
    logic [31:0] val;
    string       req;
  } exp_t;

  exp_t       sb[$];
  int         cyc = 0;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;
  logic [9:0] ir_model = RST_WORD;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops expectations due in the current window
  initial begin
    exp_t        e;
    logic [31:0] act;
    forever begin
      @(posedge clk);
      #6;
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
        e = sb.pop_front();
        case (e.kind)
          K_TDO:   act = {31'b0, tdo};
          K_ACT:   act = {28'b0, go_pulse, exit_pulse, dr_write, dr_read};
          default: act = {{(32-NR){1'b0}}, res_sel};
        endcase
        n_run++;
        if (act !== e.val || e.cyc != cyc) begin
          n_fail++;
          $display("FAIL %s kind=%0d cyc=%0d: actual=%h expected=%h",
                   e.req, e.kind, cyc, act, e.val);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic expect_at(int c, kind_t k, logic [31:0] v, string r);
    exp_t e;
    e.cyc = c; e.kind = k; e.val = v; e.req = r;
    sb.push_back(e);
  endtask

  function automatic logic [6:0] code_of(int i);
    case (i)
      0: return 7'b0010000;
      1: return 7'b0010010;
      2: return 7'b0100000;
      3: return 7'b0100001;
      4: return 7'b0100010;
      5: return 7'b0100011;
      6: return 7'b0100100;
      7: return 7'b0100101;
      default: return 7'b0100110;
    endcase
  endfunction

  function automatic logic [9:0] mk(bit rw, bit go, bit ex, logic [6:0] rs);
    logic [9:0] w;
    w[0] = rw; w[1] = go; w[2] = ex;
    for (int j = 0; j < 7; j++) w[3+j] = rs[6-j];
    return w;
  endfunction

  task automatic do_update();
    update_ir = 1'b1;
    expect_at(cyc + 1, K_ACT, 32'h0, "R6");
    tick();
    update_ir = 1'b0;
    expect_at(cyc + 1, K_ACT, 32'h0, "R6");
    tick();
    tick();
  endtask

  // R2: shifts w in, checks the previous stage contents on tdo
  task automatic load_ir(logic [9:0] w, string r, bit upd);
    for (int i = 0; i < 10; i++) begin
      shift_ir = 1'b1;
      tdi = w[i];
      expect_at(cyc, K_TDO, {31'b0, ir_model[i]}, r);
      tick();
    end
    ir_model = w;
    shift_ir = 1'b0;
    tdi = 1'b0;
    tick();
    if (upd) do_update();
  endtask

  task automatic dr_scan(int n, logic [31:0] din, mode_t m, logic [3:0] act_exp, string r);
    capture_dr = 1'b1;
    tick();
    capture_dr = 1'b0;
    for (int i = 0; i < n; i++) begin
      shift_dr = 1'b1;
      tdi = din[i];
      case (m)
        M_ID:  expect_at(cyc, K_TDO, {31'b0, IDC[i]}, r);
        M_BYP: expect_at(cyc, K_TDO, {31'b0, (i == 0) ? 1'b0 : din[i-1]}, r);
        M_EXT: begin
          ext_tdo = ~din[i];
          expect_at(cyc, K_TDO, {31'b0, ~din[i]}, "R9");
        end
        default: ;
      endcase
      tick();
    end
    shift_dr = 1'b0;
    tdi = 1'b0;
    ext_tdo = 1'b0;
    update_dr = 1'b1;
    expect_at(cyc, K_ACT, 32'h0, r);
    expect_at(cyc + 1, K_ACT, {28'b0, act_exp}, r);
    expect_at(cyc + 2, K_ACT, 32'h0, r);
    tick();
    update_dr = 1'b0;
    tick();
    tick();
  endtask

  initial begin
    tick(); tick(); tick();
    rst = 1'b0;
    tick();
    // R1: reset state
    expect_at(cyc, K_ACT, 32'h0, "R1");
    expect_at(cyc, K_SEL, 32'h0, "R1");
    tick();
    // R1, R2: reset word shifts out while an ID read is shifted in
    load_ir(mk(1, 0, 0, 7'b0000010), "R1", 1'b0);
    // R3: no update yet, so the reset selection (bypass) is still active
    dr_scan(6, 32'h2D, M_BYP, 4'b0000, "R3");
    do_update();
    expect_at(cyc, K_SEL, 32'h0, "R4");
    tick();
    // R8: ID read, no strobe
    dr_scan(32, 32'h0, M_ID, 4'b0000, "R8");
    // R8: ID write has no effect
    load_ir(mk(0, 0, 0, 7'b0000010), "R2", 1'b1);
    dr_scan(32, 32'hFFFF_FFFF, M_ID, 4'b0000, "R8");
    dr_scan(32, 32'h0, M_ID, 4'b0000, "R8");
    // R4, R5, R9: each external resource, alternating write and read
    for (int i = 0; i < NR; i++) begin
      bit rw;
      rw = (i % 2) == 1;
      load_ir(mk(rw, 0, 0, code_of(i)), "R2", 1'b1);
      expect_at(cyc, K_SEL, 32'h1 << i, "R4");
      tick();
      dr_scan(5, 32'h15 ^ i, M_EXT, rw ? 4'b0001 : 4'b0010, "R5");
    end
    // R6, R7: bypass code with go set
    load_ir(mk(0, 1, 0, 7'b0010001), "R2", 1'b1);
    expect_at(cyc, K_SEL, 32'h0, "R7");
    tick();
    dr_scan(8, 32'hA5, M_BYP, 4'b1000, "R6");
    // R7: reserved top code, write with exit set
    load_ir(mk(0, 0, 1, 7'b1111111), "R2", 1'b1);
    expect_at(cyc, K_SEL, 32'h0, "R7");
    tick();
    dr_scan(4, 32'h6, M_BYP, 4'b0100, "R7");
    // R7: reserved zero code, read
    load_ir(mk(1, 0, 0, 7'b0000000), "R2", 1'b1);
    dr_scan(5, 32'h13, M_BYP, 4'b0000, "R7");
    // R6: go and exit with a control write; update_ir alone gives nothing
    load_ir(mk(0, 1, 1, 7'b0010010), "R2", 1'b1);
    expect_at(cyc, K_ACT, 32'h0, "R6");
    expect_at(cyc, K_SEL, 32'h2, "R4");
    tick();
    dr_scan(3, 32'h5, M_EXT, 4'b1110, "R6");
    repeat (4) tick();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule